// File: doc/BRIEF.md
# Programmable-Sense External Interrupt Bank

This block takes a bank of external interrupt pins (1 to 32, set by a parameter) and turns each of them into a latched, maskable interrupt request. Every pin has its own sense setting: active-low level, active-high level, rising edge, falling edge, or either edge. Each pin is brought into the clock domain through a two-stage synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

A detected event sets a sticky detect bit for that line. Each line has its own output request toward a parent interrupt controller. That output is the detect bit gated by the line's enable bit. Software reaches the block through a plain 32-bit register bus with an address, write data, a write strobe, a read strobe and registered read data. Software sets enables by writing ones to one address and clears them by writing ones to another. Detect bits are cleared by writing one. Software can also read the live synchronized pin levels and program each line's sense code.

Top module: `ext_irq_bank`

## Requirements
- R1: After reset every enable bit, detect bit and configuration register is zero, every `irq_o` bit is low, and `bus_rdata` is zero.
- R2: Line n has a 32-bit configuration register at byte offset 0x180 + 4*n. Bits [5:0] hold the sense code. All 32 written bits are stored and read back unchanged.
- R3: Sense code 0x01 detects a low level, 0x02 a high level, 0x04 a falling edge, 0x08 a rising edge and 0x0C either edge. Any other code detects nothing on that line.
- R4: The detect register at offset 0x100 has one sticky bit per line, with bit n standing for line n. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R5: When a detection and a write-1-to-clear hit the same bit in the same cycle, the bit stays set. A level-mode line whose level is still present therefore reads back set right after it is cleared.
- R6: Writing 1 to bit n at offset 0x08 enables line n. Writing 1 to bit n at offset 0x04 disables line n. Zero bits leave the enable unchanged in both cases. Reading offset 0x04 returns the enable mask.
- R7: `irq_o[n]` is high exactly when line n's detect bit and enable bit are both set.
- R8: Reading offset 0x104 returns the synchronized pin levels. A pin change is visible there after two clock edges, and a detection from it is set at the edge after that.
- R9: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds its value otherwise. Unmapped offsets, including configuration offsets of lines beyond the parameter, read zero. Status bits above the line count read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | N_LINES | Asynchronous external interrupt pins |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle it is high |
| bus_rd | input | 1 | Read strobe; read data is loaded at this edge |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | N_LINES | Per-line interrupt request, detect AND enable |

## Verification
Each of the eight lines gets a different sense code: the five valid ones, two invalid ones and one high-level code with upper configuration bits set. One pin vector is then driven to all lines at once, so a single transition shows which sense modes react and which must stay silent. The bench first raises most pins together and then lowers them together. This separates rising, falling and both-edge detection, and shows that level lines stop setting once their level goes away. Write-1-to-clear is applied while level lines are still active and again after they have gone quiet. The two results tell the set-wins rule apart from a plain clear. A one-cycle pin pulse and zero-valued clear writes show that a short edge is still caught and that zero bits are ignored.

// File: rtl/ext_irq_bank.sv
module ext_irq_bank #(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic [N_LINES-1:0] irq_o
);

  localparam logic [ADDR_W-1:0] A_ENSTS = ADDR_W'(32'h004);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(32'h008);
  localparam logic [ADDR_W-1:0] A_DET   = ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] A_MON   = ADDR_W'(32'h104);
  localparam int                CFG_BASE = 'h180;

  logic [N_LINES-1:0] sy1, lvl, lvl_d;
  logic [N_LINES-1:0] det, en, det_set;
  logic [N_LINES-1:0] det_clr, en_on, en_off;
  logic [31:0]        cfg_rd [N_LINES];
  logic [31:0]        rd_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1   <= '0;
      lvl   <= '0;
      lvl_d <= '0;
    end else begin
      sy1   <= pin_i;
      lvl   <= sy1;
      lvl_d <= lvl;
    end
  end

  assign det_clr = (bus_wr && bus_addr == A_DET)   ? bus_wdata[N_LINES-1:0] : '0;
  assign en_on   = (bus_wr && bus_addr == A_ENSET) ? bus_wdata[N_LINES-1:0] : '0;
  assign en_off  = (bus_wr && bus_addr == A_ENSTS) ? bus_wdata[N_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det <= '0;
      en  <= '0;
    end else begin
      det <= (det & ~det_clr) | det_set;
      en  <= (en | en_on) & ~en_off;
    end
  end

  assign irq_o = det & en;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [31:0] cfg_q;
    logic        hit;
    assign hit = bus_wr && (bus_addr == ADDR_W'(CFG_BASE + 4*g));

    always_ff @(posedge clk) begin
      if (!rst_n)   cfg_q <= '0;
      else if (hit) cfg_q <= bus_wdata;
    end

    always_comb begin
      case (cfg_q[5:0])
        6'h01:   det_set[g] = ~lvl[g];
        6'h02:   det_set[g] =  lvl[g];
        6'h04:   det_set[g] =  lvl_d[g] & ~lvl[g];
        6'h08:   det_set[g] = ~lvl_d[g] &  lvl[g];
        6'h0C:   det_set[g] =  lvl_d[g] ^  lvl[g];
        default: det_set[g] = 1'b0;
      endcase
    end

    assign cfg_rd[g] = cfg_q;
  end

  always_comb begin
    rd_v = '0;
    case (bus_addr)
      A_ENSTS: rd_v[N_LINES-1:0] = en;
      A_DET:   rd_v[N_LINES-1:0] = det;
      A_MON:   rd_v[N_LINES-1:0] = lvl;
      default: rd_v = '0;
    endcase
    for (int i = 0; i < N_LINES; i++)
      if (bus_addr == ADDR_W'(CFG_BASE + 4*i)) rd_v = cfg_rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_v;
  end

  // R5
  det_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|det_set) |=> ((det & $past(det_set)) == $past(det_set)));

  // R6
  en_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENSET) |=> ((en & $past(bus_wdata[N_LINES-1:0])) == $past(bus_wdata[N_LINES-1:0])));

  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENSTS) |=> ((en & $past(bus_wdata[N_LINES-1:0])) == '0));

  // R4
  det_full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DET && bus_wdata[N_LINES-1:0] == '1 && det_set == '0) |=> (det == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata));

  // R7
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (irq_o == '0));

endmodule

// File: tb/ext_irq_bank_bench.sv
module ext_irq_bank_bench;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [N-1:0] pin_i = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_o;

  int total = 0, bad = 0;
  bit run = 0;

  ext_irq_bank #(.N_LINES(N), .ADDR_W(12)) u_ext_irq_bank (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [N-1:0] m_en, m_det;
  logic [31:0]  m_cfg [N];
  logic [31:0]  m_rd;
  logic [N-1:0] pq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_det = '0; m_rd = '0;
      for (int i = 0; i < N; i++) m_cfg[i] = '0;
      pq = {8'h00, 8'h00, 8'h00};
    end else begin
      logic [N-1:0] lv, pv, hit;
      lv = pq[pq.size()-2];
      pv = pq[pq.size()-3];
      for (int i = 0; i < N; i++) begin
        hit[i] = 1'b0;
        if (m_cfg[i][5:0] == 6'h01 && !lv[i]) hit[i] = 1'b1;
        if (m_cfg[i][5:0] == 6'h02 &&  lv[i]) hit[i] = 1'b1;
        if (m_cfg[i][5:0] == 6'h04 &&  pv[i] && !lv[i]) hit[i] = 1'b1;
        if (m_cfg[i][5:0] == 6'h08 && !pv[i] &&  lv[i]) hit[i] = 1'b1;
        if (m_cfg[i][5:0] == 6'h0C &&  pv[i] != lv[i])  hit[i] = 1'b1;
      end
      if (bus_rd) begin
        m_rd = '0;
        if (bus_addr == 12'h004) m_rd = 32'(m_en);
        else if (bus_addr == 12'h100) m_rd = 32'(m_det);
        else if (bus_addr == 12'h104) m_rd = 32'(lv);
        else if (bus_addr >= 12'h180 && bus_addr < 12'h180 + 4*N && bus_addr[1:0] == 2'b00)
          m_rd = m_cfg[(bus_addr - 12'h180) / 4];
      end
      if (bus_wr) begin
        if (bus_addr == 12'h100) m_det = m_det & ~bus_wdata[N-1:0];
        if (bus_addr == 12'h008) m_en = m_en | bus_wdata[N-1:0];
        if (bus_addr == 12'h004) m_en = m_en & ~bus_wdata[N-1:0];
        if (bus_addr >= 12'h180 && bus_addr < 12'h180 + 4*N && bus_addr[1:0] == 2'b00)
          m_cfg[(bus_addr - 12'h180) / 4] = bus_wdata;
      end
      m_det = m_det | hit;
      pq.push_back(pin_i);
      if (pq.size() > 4) void'(pq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (run) begin
      chk("R7 irq_o vs model", 32'(irq_o), 32'(m_det & m_en));
      chk("R9 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run = 1;

    // R1: reset state
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rreg(12'h100, d); chk("R1 detect after reset", d, 32'h0);
    rreg(12'h004, d); chk("R1 enable after reset", d, 32'h0);
    rreg(12'h180, d); chk("R1 config after reset", d, 32'h0);

    // R2/R3: one sense code per line
    wreg(12'h180, 32'h01);
    wreg(12'h184, 32'h02);
    wreg(12'h188, 32'h04);
    wreg(12'h18C, 32'h08);
    wreg(12'h190, 32'h0C);
    wreg(12'h194, 32'h03);
    wreg(12'h198, 32'h10);
    wreg(12'h19C, 32'hABCD_0002);
    rreg(12'h19C, d); chk("R2 config upper bits kept", d, 32'hABCD_0002);
    rreg(12'h194, d); chk("R2 config invalid code stored", d, 32'h03);
    idle(4);
    rreg(12'h100, d); chk("R3 low level with pins low", d, 32'h01);
    chk("R7 no irq without enable", 32'(irq_o), 32'h0);

    // R6: enable set/clear
    wreg(12'h008, 32'hFF);
    rreg(12'h004, d); chk("R6 enable set", d, 32'hFF);
    chk("R7 irq after enable", 32'(irq_o), 32'h01);
    wreg(12'h004, 32'h01);
    rreg(12'h004, d); chk("R6 enable clear", d, 32'hFE);
    wreg(12'h008, 32'h00);
    rreg(12'h004, d); chk("R6 zero set write ignored", d, 32'hFE);

    // R3/R8: raise pins 1..7
    @(negedge clk); pin_i = 8'hFE;
    idle(1);
    rreg(12'h104, d); chk("R8 monitor after two edges", d, 32'hFE);
    idle(3);
    rreg(12'h100, d); chk("R3 rising pattern", d, 32'h9B);

    // R5: clear while level lines active
    wreg(12'h100, 32'hFF);
    rreg(12'h100, d); chk("R5 level lines set again", d, 32'h83);
    wreg(12'h100, 32'h00);
    rreg(12'h100, d); chk("R4 zero write ignored", d, 32'h83);

    // R3: lower all pins
    @(negedge clk); pin_i = 8'h00;
    idle(5);
    rreg(12'h100, d); chk("R3 falling pattern", d, 32'h97);
    wreg(12'h100, 32'h16);
    rreg(12'h100, d); chk("R4 partial clear", d, 32'h81);
    chk("R7 irq masked by enable", 32'(irq_o), 32'h80);
    rreg(12'h104, d); chk("R8 monitor low", d, 32'h00);

    // one-cycle pulse on line 3 (rising edge)
    wreg(12'h100, 32'hFE);
    @(negedge clk); pin_i = 8'h08;
    @(negedge clk); pin_i = 8'h00;
    idle(5);
    rreg(12'h100, d); chk("R3 short pulse rise and both-edge idle", d, 32'h09);

    // R9: unmapped and out-of-range reads
    rreg(12'h00C, d); chk("R9 unmapped offset", d, 32'h0);
    rreg(12'h1A0, d); chk("R9 config beyond line count", d, 32'h0);
    rreg(12'h000, d); chk("R9 offset zero", d, 32'h0);
    idle(3);
    chk("R9 rdata held without read", bus_rdata, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule